// File: doc/BRIEF.md
# Multi-mode interrupt vector resolver

This block sits on the processor side of a maskable interrupt. When the core accepts an interrupt and raises an acknowledge, the block takes one byte from the data bus and turns it into a handler address. It also asks the core to push the current program counter. A small mode register, loaded by a set-mode command, picks one of three ways to resolve the byte:
- Mode 0 treats the byte as a restart opcode and jumps to one of eight low addresses.
- Mode 1 ignores the byte and always goes to 0x0038.
- Mode 2 joins an 8-bit page register and the byte into a table address, then reads a 16-bit handler word from memory.

In mode 2 the block reads the word in two steps through a simple request/acknowledge memory port. It reads the low byte first, then the high byte at the next address. Loading a new page value moves all later lookups to a different 256-byte table. Nothing else changes.

Top module: `irq_vector_resolver`

## Requirements
- R1: After reset the mode is 0 and the page is 0x00. vec_valid_o, push_req_o, bad_op_o and mem_req_o are all low.
- R2: A pulse on set_mode_i loads mode_i when it is 0, 1 or 2. A value of 3 is ignored and the previous mode is kept.
- R3: In mode 0 a bus byte of the form 11xxx111b produces vec_addr_o = xxx*8 (0x0000 to 0x0038). vec_valid_o and push_req_o are high for exactly the one cycle after the acknowledge edge.
- R4: In mode 0, any other bus byte raises bad_op_o for one cycle after the acknowledge edge. vec_valid_o and push_req_o stay low.
- R5: In mode 1, every acknowledge produces vec_addr_o = 0x0038 whatever the bus byte is. vec_valid_o and push_req_o are high in the cycle after the acknowledge edge.
- R6: In mode 2, the cycle after the acknowledge edge raises mem_req_o with mem_addr_o = {page, bus byte}. Both hold until mem_ack_i is seen. mem_data_i at that edge is the low byte.
- R7: After the low byte, mem_addr_o becomes the first address plus 1 (a 16-bit increment). The byte taken with the next mem_ack_i is the high byte. In the cycle after that edge, vec_valid_o and push_req_o are high with vec_addr_o = {high, low}.
- R8: push_pc_o holds the pc_i value sampled at the acknowledge edge whenever push_req_o is high.
- R9: An acknowledge that arrives while a mode 2 fetch is in progress (busy_o high) is ignored. It changes neither the result nor push_pc_o.
- R10: A set-mode or set-page command in the same cycle as an acknowledge does not affect that acknowledge. It applies from the next one.
- R11: A new page value redirects a later mode 2 lookup of the same bus byte to the new table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_mode_i | input | 1 | Set-mode command strobe |
| mode_i | input | 2 | Mode number carried by the command |
| set_page_i | input | 1 | Page register load strobe |
| page_i | input | 8 | New page value |
| ack_i | input | 1 | Interrupt acknowledge, one cycle |
| data_i | input | 8 | Data bus byte sampled on acknowledge |
| pc_i | input | 16 | Current program counter |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 16 | Table read address |
| mem_ack_i | input | 1 | Table read done |
| mem_data_i | input | 8 | Table read data |
| busy_o | output | 1 | Mode 2 fetch in progress |
| vec_valid_o | output | 1 | Handler address valid, one cycle |
| vec_addr_o | output | 16 | Handler address |
| push_req_o | output | 1 | Request to push the program counter |
| push_pc_o | output | 16 | Program counter value to push |
| bad_op_o | output | 1 | Unsupported mode 0 opcode, one cycle |

## Verification
The collision of interest is a configuration write landing in the same cycle as an acknowledge. This happens with a set-mode command during a mode 1 acknowledge and with a set-page command during a mode 2 acknowledge. The bench drives both strobes on the same negative edge. It then judges the result from vec_addr_o and the first mem_addr_o, which must reflect the old settings, and from the next acknowledge, which must reflect the new ones. A second overlap is an acknowledge inside a running table fetch. It is judged by comparing the result and push_pc_o with the first request's values.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {
    MODE_RST = 2'd0,
    MODE_FIX = 2'd1,
    MODE_TBL = 2'd2,
    MODE_RSV = 2'd3
  } irq_mode_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_LO   = 2'd1,
    F_HI   = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/irqv_cfg.sv
module irqv_cfg
  import irqv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_mode_i,
  input  logic [1:0]    mode_i,
  input  logic          set_page_i,
  input  logic [DW-1:0] page_i,
  output irq_mode_e     mode_o,
  output logic [DW-1:0] page_o
);
  irq_mode_e     mode_q;
  logic [DW-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      page_q <= '0;
    end else begin
      if (set_mode_i && irq_mode_e'(mode_i) != MODE_RSV) mode_q <= irq_mode_e'(mode_i);
      if (set_page_i) page_q <= page_i;
    end
  end

  assign mode_o = mode_q;
  assign page_o = page_q;

  // R2
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != MODE_RSV);

  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mode_i && mode_i == 2'd3) |=> $stable(mode_q));
endmodule

// File: rtl/irqv_rst_dec.sv
module irqv_rst_dec
  import irqv_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          AW        = 16,
  parameter logic [15:0] FIXED_VEC = 16'h0038
) (
  input  irq_mode_e     mode_i,
  input  logic [DW-1:0] byte_i,
  output logic          hit_o,
  output logic [AW-1:0] target_o
);
  // restart opcode: 11 ttt 111, target ttt*8
  logic is_rst;
  assign is_rst = (byte_i[7:6] == 2'b11) && (byte_i[2:0] == 3'b111);

  always_comb begin
    hit_o    = 1'b0;
    target_o = '0;
    unique case (mode_i)
      MODE_FIX: begin
        hit_o    = 1'b1;
        target_o = AW'(FIXED_VEC);
      end
      MODE_RST: begin
        hit_o    = is_rst;
        target_o = AW'({byte_i[5:3], 3'b000});
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irqv_fetch.sv
module irqv_fetch
  import irqv_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_data_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] word_o
);
  fetch_st_e     st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      unique case (st_q)
        F_IDLE: if (start_i) begin
          st_q   <= F_LO;
          addr_q <= base_i;
        end
        F_LO: if (mem_ack_i) begin
          st_q   <= F_HI;
          lo_q   <= mem_data_i;
          addr_q <= addr_q + AW'(1);
        end
        F_HI: if (mem_ack_i) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign busy_o     = st_q != F_IDLE;
  assign mem_req_o  = busy_o;
  assign mem_addr_o = addr_q;
  assign done_o     = (st_q == F_HI) && mem_ack_i;
  assign word_o     = {mem_data_i, lo_q};

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R7
  hi_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == F_LO && mem_ack_i) |=> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver
  import irqv_pkg::*;
#(
  parameter int          DW        = 8,
  parameter logic [15:0] FIXED_VEC = 16'h0038
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_mode_i,
  input  logic [1:0]          mode_i,
  input  logic                set_page_i,
  input  logic [DW-1:0]       page_i,
  input  logic                ack_i,
  input  logic [DW-1:0]       data_i,
  input  logic [2*DW-1:0]     pc_i,
  output logic                mem_req_o,
  output logic [2*DW-1:0]     mem_addr_o,
  input  logic                mem_ack_i,
  input  logic [DW-1:0]       mem_data_i,
  output logic                busy_o,
  output logic                vec_valid_o,
  output logic [2*DW-1:0]     vec_addr_o,
  output logic                push_req_o,
  output logic [2*DW-1:0]     push_pc_o,
  output logic                bad_op_o
);
  localparam int AW = 2 * DW;

  irq_mode_e     mode;
  logic [DW-1:0] page;
  logic          hit, accept, done;
  logic [AW-1:0] target, word;

  irqv_cfg #(.DW(DW)) i_cfg (
    .clk_i, .rst_ni, .set_mode_i, .mode_i, .set_page_i, .page_i,
    .mode_o(mode), .page_o(page)
  );

  irqv_rst_dec #(.DW(DW), .AW(AW), .FIXED_VEC(FIXED_VEC)) i_dec (
    .mode_i(mode), .byte_i(data_i), .hit_o(hit), .target_o(target)
  );

  assign accept = ack_i && !busy_o;

  irqv_fetch #(.DW(DW), .AW(AW)) i_fetch (
    .clk_i, .rst_ni,
    .start_i(accept && mode == MODE_TBL),
    .base_i({page, data_i}),
    .mem_ack_i, .mem_data_i, .mem_req_o, .mem_addr_o,
    .busy_o, .done_o(done), .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      push_req_o  <= 1'b0;
      bad_op_o    <= 1'b0;
      vec_addr_o  <= '0;
      push_pc_o   <= '0;
    end else begin
      vec_valid_o <= 1'b0;
      push_req_o  <= 1'b0;
      bad_op_o    <= 1'b0;
      if (accept) begin
        push_pc_o <= pc_i;
        if (mode != MODE_TBL) begin
          if (hit) begin
            vec_valid_o <= 1'b1;
            push_req_o  <= 1'b1;
            vec_addr_o  <= target;
          end else begin
            bad_op_o <= 1'b1;
          end
        end
      end
      if (done) begin
        vec_valid_o <= 1'b1;
        push_req_o  <= 1'b1;
        vec_addr_o  <= word;
      end
    end
  end

  // R5
  fixed_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mode == MODE_FIX) |=> (vec_valid_o && vec_addr_o == AW'(FIXED_VEC)));

  // R4
  bad_op_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_op_o |-> (!vec_valid_o && !push_req_o));

  // R6
  tbl_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mode == MODE_TBL) |=> (mem_req_o && mem_addr_o == $past({page, data_i})));

  // R8
  push_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !accept) |=> $stable(push_pc_o));
endmodule

// File: tb/test_irq_vector_resolver.sv
module test_irq_vector_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_mode = 1'b0, set_page = 1'b0, ack = 1'b0, mem_ack = 1'b0;
  logic [1:0]  mode = '0;
  logic [7:0]  page = '0, data = '0, mem_data = '0;
  logic [15:0] pc = '0;
  logic        mem_req, busy, vec_valid, push_req, bad_op;
  logic [15:0] mem_addr, vec_addr, push_pc;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_vector_resolver i_irq_vector_resolver (
    .clk_i(clk), .rst_ni(rst_n), .set_mode_i(set_mode), .mode_i(mode),
    .set_page_i(set_page), .page_i(page), .ack_i(ack), .data_i(data), .pc_i(pc),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_data_i(mem_data),
    .busy_o(busy), .vec_valid_o(vec_valid), .vec_addr_o(vec_addr),
    .push_req_o(push_req), .push_pc_o(push_pc), .bad_op_o(bad_op)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] m, logic [7:0] p);
    @(negedge clk); set_mode = 1'b1; mode = m; set_page = 1'b1; page = p;
    @(negedge clk); set_mode = 1'b0; set_page = 1'b0;
  endtask

  // ack; afterwards we are in the cycle after the ack edge
  task automatic do_ack(logic [7:0] b, logic [15:0] p);
    @(negedge clk); ack = 1'b1; data = b; pc = p;
    @(negedge clk); ack = 1'b0;
  endtask

  // serve a two-byte table read; ends in the cycle after the last mem ack edge
  task automatic serve(string req, logic [15:0] a, logic [15:0] w);
    chk(req, {15'd0, mem_req}, 16'd1);
    chk(req, mem_addr, a);
    mem_ack = 1'b1; mem_data = w[7:0];
    @(negedge clk); mem_data = w[15:8];
    chk(req, mem_addr, a + 16'd1);
    @(negedge clk); mem_ack = 1'b0;
  endtask

  // mode, page, bus byte, table word, expected address, expected bad
  localparam int NV = 9;
  localparam logic [66:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'hC7, 16'h0000, 16'h0000, 1'b0, 16'h1000},
    {2'd0, 8'h00, 8'hFF, 16'h0000, 16'h0038, 1'b0, 16'h1001},
    {2'd0, 8'h00, 8'hD7, 16'h0000, 16'h0010, 1'b0, 16'h1002},
    {2'd0, 8'h00, 8'h3C, 16'h0000, 16'h0000, 1'b1, 16'h1003},
    {2'd0, 8'h00, 8'hC6, 16'h0000, 16'h0000, 1'b1, 16'h1004},
    {2'd1, 8'h00, 8'h5A, 16'h0000, 16'h0038, 1'b0, 16'h1005},
    {2'd2, 8'h12, 8'h04, 16'hBEEF, 16'hBEEF, 1'b0, 16'h1006},
    {2'd2, 8'h34, 8'h04, 16'h4321, 16'h4321, 1'b0, 16'h1007},
    {2'd2, 8'hA0, 8'hFF, 16'h7E01, 16'h7E01, 1'b0, 16'h1008}
  };

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {12'd0, vec_valid, push_req, bad_op, mem_req}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {12'd0, vec_valid, push_req, bad_op, mem_req}, 16'd0);
    // R1 mode 0 after reset: restart 3 -> 0x18
    do_ack(8'hDF, 16'h0BAD);
    chk("R1", vec_addr, 16'h0018);
    chk("R1", {15'd0, vec_valid}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  m  = VEC[i][66:65];
      logic [7:0]  p  = VEC[i][64:57];
      logic [7:0]  b  = VEC[i][56:49];
      logic [15:0] w  = VEC[i][48:33];
      logic [15:0] ea = VEC[i][32:17];
      logic        eb = VEC[i][16];
      logic [15:0] pv = VEC[i][15:0];
      cfg(m, p);
      do_ack(b, pv);
      if (m == 2'd2) serve("R6 R7 R11", {p, b}, w);
      if (eb) begin
        chk("R4", {14'd0, bad_op, vec_valid | push_req}, 16'd2);
      end else begin
        chk("R3 R5 R7", {14'd0, vec_valid, push_req}, 16'd3);
        chk("R3 R5 R7 R11", vec_addr, ea);
        chk("R8", push_pc, pv);
      end
      @(negedge clk);
      chk("R3", {14'd0, vec_valid, bad_op}, 16'd0);
    end

    // R2: mode 3 ignored, mode 1 kept
    cfg(2'd1, 8'h00);
    cfg(2'd3, 8'h00);
    do_ack(8'hC7, 16'h2000);
    chk("R2", vec_addr, 16'h0038);

    // R10: set-mode in same cycle as ack uses old mode
    @(negedge clk); ack = 1'b1; data = 8'hCF; set_mode = 1'b1; mode = 2'd0;
    @(negedge clk); ack = 1'b0; set_mode = 1'b0;
    chk("R10", vec_addr, 16'h0038);
    do_ack(8'hCF, 16'h2001);
    chk("R10", vec_addr, 16'h0008);

    // R10: set-page in same cycle as ack in mode 2
    cfg(2'd2, 8'h55);
    @(negedge clk); ack = 1'b1; data = 8'h10; pc = 16'h3000; set_page = 1'b1; page = 8'h66;
    @(negedge clk); ack = 1'b0; set_page = 1'b0;
    serve("R10", 16'h5510, 16'hCAFE);
    chk("R10", vec_addr, 16'hCAFE);
    do_ack(8'h10, 16'h3001);
    chk("R10", mem_addr, 16'h6610);
    serve("R10", 16'h6610, 16'h1234);
    chk("R10", vec_addr, 16'h1234);

    // R9: ack during fetch is ignored
    do_ack(8'h20, 16'h4000);
    chk("R9", {15'd0, busy}, 16'd1);
    ack = 1'b1; data = 8'h30; pc = 16'h4444;
    @(negedge clk); ack = 1'b0;
    chk("R9", mem_addr, 16'h6620);
    serve("R9", 16'h6620, 16'hA5A5);
    chk("R9", vec_addr, 16'hA5A5);
    chk("R9", push_pc, 16'h4000);
    @(negedge clk);
    chk("R9", {14'd0, busy, vec_valid}, 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule